// File: doc/BRIEF.md
# Subsystem Power-Up Sequencer

This block is a hardware sequencer that takes a processor subsystem from a held, unpowered state to a running core. One start pulse launches a fixed series of steps. It holds the core in reset, turns on the oscillator clock branch and waits for that clock to report running. It then closes the power headswitch, bypasses the regulator, lifts clamps and the retention and standby controls, and powers the memory banks one by one. Last, it releases the core and waits for the core's boot firmware to report a status.

Every delay and timeout is counted in pulses of a one-cycle microsecond tick supplied from outside, so the same netlist works at any system clock. The number of memory banks depends on a variant select, which is sampled when the start pulse is accepted. When the run ends, the outcome stays on a two-bit result code and the block returns to idle. On a failure it leaves every control where it stood and raises a sticky error flag, which the next accepted start clears.

Top module: `subsys_pwrup_seq`

## Requirements
- R1: After reset, `busy_o`, `err_o`, `result_o` (0 = none), all reset/stop/enable/retention outputs and `bank_pwr_o` are 0, while `mem_clamp_o`, `wl_clamp_o` and `io_clamp_o` are 1.
- R2: One cycle after an accepted start, `core_rst_o`, `bus_rst_o` and `stop_core_o` are all 1, and `xo_clk_en_o` and `hsw_on_o` are still 0.
- R3: After `xo_clk_en_o` rises, the sequence goes on only when `xo_clkoff_i` is seen low. If it is still high after `XO_TMO_TICKS` ticks, the run ends with result 2 (timeout) and `err_o` = 1.
- R4: `ldo_byp_o` rises only after at least `SETTLE_TICKS+1` ticks have been delivered since `hsw_on_o` rose.
- R5: After the regulator bypass, `mem_clamp_o` falls first. Then `ret_n_o` and `l2_stby_n_o` rise together, before any memory bank is powered.
- R6: Memory bank bits turn on one per step, from the top index down to bit 0. Bits already on stay on, and each new bit waits at least `SETTLE_TICKS+1` ticks after the previous one.
- R7: With `variant_i` = 0 at start the top bank is 19 (20 banks). With `variant_i` = 1 it is 28 (29 banks).
- R8: After the last bank, these occur in strict order, one per step: `wl_clamp_o` falls, `io_clamp_o` falls, `core_rst_o` falls, `core_clk_en_o` rises, and last `stop_core_o` falls.
- R9: After `stop_core_o` falls, a `boot_valid_i` pulse ends the run. If `boot_code_i` equals `OK_CODE` (1), the result is 1 (ok). Any other code gives result 3 (bad status) with `err_o` = 1. No pulse within `BOOT_TMO_TICKS` ticks gives result 2 with `err_o` = 1.
- R10: A start pulse while `busy_o` = 1 is ignored: the powered banks are kept and the run finishes normally.
- R11: On an abort, every control output keeps its value. `err_o` stays 1 until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| variant_i | input | 1 | Bank-count select, sampled at start |
| xo_clkoff_i | input | 1 | Oscillator branch clock-off status |
| boot_valid_i | input | 1 | Boot status valid pulse |
| boot_code_i | input | CODE_W (8) | Boot status code |
| core_rst_o | output | 1 | Core reset |
| bus_rst_o | output | 1 | Bus reset |
| stop_core_o | output | 1 | Hold core execution |
| xo_clk_en_o | output | 1 | Oscillator clock branch enable |
| core_clk_en_o | output | 1 | Core clock enable |
| hsw_on_o | output | 1 | Power headswitch on |
| ldo_byp_o | output | 1 | Regulator bypass |
| mem_clamp_o | output | 1 | Memory clamp |
| wl_clamp_o | output | 1 | Word-line clamp |
| io_clamp_o | output | 1 | IO clamp |
| ret_n_o | output | 1 | Sleep-retention deassert (1 = released) |
| l2_stby_n_o | output | 1 | L2 standby deassert (1 = released) |
| bank_pwr_o | output | NBANK (29) | Per-bank memory power |
| busy_o | output | 1 | Sequence in progress |
| result_o | output | 2 | 0 none, 1 ok, 2 timeout, 3 bad status |
| err_o | output | 1 | Sticky error flag |

## Verification
The bench stops the oscillator handshake to force a timeout, withholds the boot pulse, and sends both a wrong code and a zero code. A design that mixed up these outcomes would report ok, or would leave `err_o` low after a failure. A monitor watches every bank change and catches a ladder that skips a bank, clears an earlier bank, starts below the top index, or shortens the settle gap measured in delivered ticks. Swapped variants then show up as a 20/29 bank count mismatch. The release order is checked by time stamps. A start injected mid-ladder would, in a design that restarted, clear the powered banks. After an abort, the bench checks that the held controls and the flag persist until the next start clears them.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the power-up sequencer: result codes and FSM states.
// Assumes: consumers import this package; codes are part of the port contract.
package pwrseq_pkg;
    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_OK   = 2'd1,
        RES_TMO  = 2'd2,
        RES_BAD  = 2'd3
    } res_e;

    typedef enum logic [4:0] {
        S_IDLE, S_RST, S_XO_EN, S_XO_WAIT, S_HSW, S_HSW_WAIT, S_LDO,
        S_MCLAMP, S_RET, S_BANK, S_BANK_WAIT, S_WL, S_IO, S_CRST,
        S_CCLK, S_STOP, S_BOOT
    } st_e;
endpackage

// File: rtl/pwrseq_tick_timer.sv
`timescale 1ns/1ps
// Tick counter: counts microsecond tick pulses since the last clear and flags
// when the count has reached the selected limit. Saturates at all-ones.
// Assumes: clr_i is pulsed in the cycle that enters a waiting state.
module pwrseq_tick_timer #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          hit_o
);
    logic [CW-1:0] cnt_q;

    // Count delivered ticks, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_q <= '0;
        else if (tick_i && (cnt_q != '1))
            cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o = (cnt_q >= limit_i);

    // Without a tick the count cannot move, so no delay is shortened.
    p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tick_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pwrseq_bank_ladder.sv
`timescale 1ns/1ps
// Bank power ladder: holds the per-bank power vector and a descending index.
// load_i sets the index to the top bank, fire_i turns the indexed bank on,
// step_i moves the index down by one. Bits only ever accumulate until clr_i.
// Assumes: the controller never steps below index 0.
module pwrseq_bank_ladder #(
    parameter int NBANK = 29,
    parameter int IW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [IW-1:0]    top_i,
    input  logic             fire_i,
    input  logic             step_i,
    output logic [NBANK-1:0] vec_o,
    output logic             last_o
);
    logic [IW-1:0] idx_q;

    // Track the bank index currently being powered.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            idx_q <= '0;
        else if (load_i)
            idx_q <= top_i;
        else if (step_i)
            idx_q <= idx_q - 1'b1;
    end

    // One sticky power bit per bank.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)
                vec_o[g] <= 1'b0;
            else if (fire_i && (idx_q == IW'(g)))
                vec_o[g] <= 1'b1;
        end
    end

    assign last_o = (idx_q == '0);

    // Powered banks are never dropped except by an explicit clear.
    p_bank_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (($past(vec_o) & ~vec_o) == '0));
endmodule

// File: rtl/subsys_pwrup_seq.sv
`timescale 1ns/1ps
// Subsystem power-up sequencer. On an accepted start it walks a fixed series:
// hold resets, oscillator clock handshake, headswitch, settle, regulator
// bypass, memory clamp, retention/standby, bank ladder (top down), word-line
// clamp, IO clamp, core reset release, core clock, stop release, boot wait.
// Assumes: tick_i is a one-cycle pulse per microsecond; all waits are in ticks.
// On abort all controls hold and err_o stays set until the next start.
module subsys_pwrup_seq
    import pwrseq_pkg::*;
#(
    parameter int TOP_A          = 19,
    parameter int TOP_B          = 28,
    parameter int SETTLE_TICKS   = 1,
    parameter int XO_TMO_TICKS   = 200,
    parameter int BOOT_TMO_TICKS = 1000000,
    parameter int CODE_W         = 8,
    parameter int OK_CODE        = 1,
    localparam int NBANK   = ((TOP_B > TOP_A) ? TOP_B : TOP_A) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              variant_i,
    input  logic              xo_clkoff_i,
    input  logic              boot_valid_i,
    input  logic [CODE_W-1:0] boot_code_i,
    output logic              core_rst_o,
    output logic              bus_rst_o,
    output logic              stop_core_o,
    output logic              xo_clk_en_o,
    output logic              core_clk_en_o,
    output logic              hsw_on_o,
    output logic              ldo_byp_o,
    output logic              mem_clamp_o,
    output logic              wl_clamp_o,
    output logic              io_clamp_o,
    output logic              ret_n_o,
    output logic              l2_stby_n_o,
    output logic [NBANK-1:0]  bank_pwr_o,
    output logic              busy_o,
    output logic [1:0]        result_o,
    output logic              err_o
);
    localparam int IW      = $clog2(NBANK);
    localparam int LIM_A   = (XO_TMO_TICKS > BOOT_TMO_TICKS) ? XO_TMO_TICKS : BOOT_TMO_TICKS;
    localparam int LIM_MAX = (LIM_A > SETTLE_TICKS + 1) ? LIM_A : SETTLE_TICKS + 1;
    localparam int CW      = $clog2(LIM_MAX + 1);

    st_e           state_q;
    res_e          res_q;
    logic          var_q;
    logic          accept, tmr_clr, tmr_hit, lad_last;
    logic [CW-1:0] lim;

    assign accept  = (state_q == S_IDLE) && start_i;
    assign tmr_clr = (state_q == S_XO_EN) || (state_q == S_HSW) ||
                     (state_q == S_BANK)  || (state_q == S_STOP);

    // Select the tick limit that applies to the current waiting state.
    always_comb begin
        case (state_q)
            S_XO_WAIT: lim = CW'(XO_TMO_TICKS);
            S_BOOT:    lim = CW'(BOOT_TMO_TICKS);
            default:   lim = CW'(SETTLE_TICKS + 1);
        endcase
    end

    pwrseq_tick_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .tick_i(tick_i),
        .limit_i(lim), .hit_o(tmr_hit)
    );

    pwrseq_bank_ladder #(.NBANK(NBANK), .IW(IW)) u_lad (
        .clk(clk), .rst_n(rst_n), .clr_i(accept),
        .load_i(state_q == S_RET),
        .top_i(var_q ? IW'(TOP_B) : IW'(TOP_A)),
        .fire_i(state_q == S_BANK),
        .step_i((state_q == S_BANK_WAIT) && tmr_hit && !lad_last),
        .vec_o(bank_pwr_o), .last_o(lad_last)
    );

    // Sequence state and registered control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;  res_q <= RES_NONE; err_o <= 1'b0; var_q <= 1'b0;
            core_rst_o <= 1'b0; bus_rst_o <= 1'b0; stop_core_o <= 1'b0;
            xo_clk_en_o <= 1'b0; core_clk_en_o <= 1'b0; hsw_on_o <= 1'b0;
            ldo_byp_o <= 1'b0; mem_clamp_o <= 1'b1; wl_clamp_o <= 1'b1;
            io_clamp_o <= 1'b1; ret_n_o <= 1'b0; l2_stby_n_o <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start_i) begin
                    core_rst_o <= 1'b1; bus_rst_o <= 1'b1; stop_core_o <= 1'b1;
                    xo_clk_en_o <= 1'b0; core_clk_en_o <= 1'b0; hsw_on_o <= 1'b0;
                    ldo_byp_o <= 1'b0; mem_clamp_o <= 1'b1; wl_clamp_o <= 1'b1;
                    io_clamp_o <= 1'b1; ret_n_o <= 1'b0; l2_stby_n_o <= 1'b0;
                    err_o <= 1'b0; res_q <= RES_NONE; var_q <= variant_i;
                    state_q <= S_RST;
                end
                S_RST:   state_q <= S_XO_EN;
                S_XO_EN: begin xo_clk_en_o <= 1'b1; state_q <= S_XO_WAIT; end
                S_XO_WAIT: begin
                    if (!xo_clkoff_i)
                        state_q <= S_HSW;
                    else if (tmr_hit) begin
                        res_q <= RES_TMO; err_o <= 1'b1; state_q <= S_IDLE;
                    end
                end
                S_HSW:      begin hsw_on_o <= 1'b1; state_q <= S_HSW_WAIT; end
                S_HSW_WAIT: if (tmr_hit) state_q <= S_LDO;
                S_LDO:      begin ldo_byp_o <= 1'b1; state_q <= S_MCLAMP; end
                S_MCLAMP:   begin mem_clamp_o <= 1'b0; state_q <= S_RET; end
                S_RET: begin
                    ret_n_o <= 1'b1; l2_stby_n_o <= 1'b1; state_q <= S_BANK;
                end
                S_BANK:      state_q <= S_BANK_WAIT;
                S_BANK_WAIT: if (tmr_hit) state_q <= lad_last ? S_WL : S_BANK;
                S_WL:   begin wl_clamp_o <= 1'b0; state_q <= S_IO; end
                S_IO:   begin io_clamp_o <= 1'b0; state_q <= S_CRST; end
                S_CRST: begin core_rst_o <= 1'b0; state_q <= S_CCLK; end
                S_CCLK: begin core_clk_en_o <= 1'b1; state_q <= S_STOP; end
                S_STOP: begin stop_core_o <= 1'b0; state_q <= S_BOOT; end
                S_BOOT: begin
                    if (boot_valid_i) begin
                        if (boot_code_i == CODE_W'(OK_CODE)) res_q <= RES_OK;
                        else begin res_q <= RES_BAD; err_o <= 1'b1; end
                        state_q <= S_IDLE;
                    end else if (tmr_hit) begin
                        res_q <= RES_TMO; err_o <= 1'b1; state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != S_IDLE);
    assign result_o = res_q;

    // Regulator bypass only with the headswitch closed.
    p_ldo_after_hsw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ldo_byp_o |-> hsw_on_o);
    // Headswitch only after the oscillator branch is enabled.
    p_hsw_after_xo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hsw_on_o |-> xo_clk_en_o);
    // Stop release is the final step of the release chain.
    p_stop_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_core_o) |-> (core_clk_en_o && !core_rst_o && !io_clamp_o && !wl_clamp_o));
    // No result is shown while a run is in progress.
    p_result_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (result_o == RES_NONE));
    // The error flag always pairs with a failing result.
    p_err_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ((result_o == RES_TMO) || (result_o == RES_BAD)));
    // A start during a run does not wipe powered banks.
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && (bank_pwr_o != '0)) |=> (bank_pwr_o != '0));
endmodule

// File: tb/sim_subsys_pwrup_seq.sv
`timescale 1ns/1ps
module sim_subsys_pwrup_seq;
    localparam int SETTLE = 1;
    localparam int NB     = 29;

    typedef struct packed {
        logic       var_sel;
        logic       stuck;
        logic       send;
        logic [7:0] code;
        logic [1:0] exp_res;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 8'h01, 2'd1},
        '{1'b1, 1'b0, 1'b1, 8'h01, 2'd1},
        '{1'b0, 1'b1, 1'b0, 8'h00, 2'd2},
        '{1'b1, 1'b0, 1'b1, 8'h5A, 2'd3},
        '{1'b0, 1'b0, 1'b0, 8'h00, 2'd2},
        '{1'b1, 1'b0, 1'b1, 8'h00, 2'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, tick_i = 1'b0, variant_i = 1'b0, xo_clkoff_i = 1'b1;
    logic boot_valid_i = 1'b0;
    logic [7:0] boot_code_i = 8'h00;
    logic core_rst_o, bus_rst_o, stop_core_o, xo_clk_en_o, core_clk_en_o;
    logic hsw_on_o, ldo_byp_o, mem_clamp_o, wl_clamp_o, io_clamp_o;
    logic ret_n_o, l2_stby_n_o, busy_o, err_o;
    logic [NB-1:0] bank_pwr_o;
    logic [1:0] result_o;

    always #2.5 clk = ~clk;

    subsys_pwrup_seq #(.SETTLE_TICKS(SETTLE), .XO_TMO_TICKS(10),
                       .BOOT_TMO_TICKS(40)) u0 (.*);

    int tests = 0, fails = 0;
    logic done = 1'b0;
    logic stuck = 1'b0;
    logic cur_var = 1'b0;
    int arm_seq = 0, seen_seq = 0;
    int cyc = 0, tickcnt = 0, tick_ph = 0;
    int st [11];
    int t_hsw = 0, t_bank = 0;
    int bad_r4 = 0, bad_r6 = 0;
    logic p_xo = 0, p_hsw = 0, p_ldo = 0, p_mcl = 1, p_ret = 0, p_wl = 1;
    logic p_io = 1, p_crst = 0, p_cclk = 0, p_stop = 0;
    logic [NB-1:0] p_bank = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Monitor: stamps events, checks ladder and settle gaps, drives tick and clock-off.
    always @(negedge clk) begin
        logic [NB-1:0] diff, low;
        cyc++;
        if (arm_seq != seen_seq) begin
            seen_seq = arm_seq;
            for (int k = 0; k < 11; k++) st[k] = 0;
        end
        if (xo_clk_en_o && !p_xo && st[0] == 0) st[0] = cyc;
        if (hsw_on_o && !p_hsw) begin st[1] = cyc; t_hsw = tickcnt; end
        if (ldo_byp_o && !p_ldo) begin
            st[2] = cyc;
            if (tickcnt - t_hsw < SETTLE + 1) bad_r4++;
        end
        if (!mem_clamp_o && p_mcl) st[3] = cyc;
        if (ret_n_o && !p_ret) st[4] = cyc;
        if (bank_pwr_o != p_bank && bank_pwr_o != '0) begin
            diff = bank_pwr_o & ~p_bank;
            if ((p_bank & ~bank_pwr_o) != '0) bad_r6++;
            if ($countones(diff) != 1) bad_r6++;
            if (p_bank == '0) begin
                st[5] = cyc;
                if (diff != (NB'(1) << (cur_var ? 28 : 19))) bad_r6++;
                if (!(ret_n_o && l2_stby_n_o)) bad_r6++;
            end else begin
                low = p_bank & (~p_bank + 1'b1);
                if (diff >= low) bad_r6++;
                if (tickcnt - t_bank < SETTLE + 1) bad_r6++;
            end
            t_bank = tickcnt;
        end
        if (!wl_clamp_o && p_wl) st[6] = cyc;
        if (!io_clamp_o && p_io) st[7] = cyc;
        if (!core_rst_o && p_crst) st[8] = cyc;
        if (core_clk_en_o && !p_cclk) st[9] = cyc;
        if (!stop_core_o && p_stop) st[10] = cyc;
        p_xo = xo_clk_en_o; p_hsw = hsw_on_o; p_ldo = ldo_byp_o; p_mcl = mem_clamp_o;
        p_ret = ret_n_o; p_wl = wl_clamp_o; p_io = io_clamp_o; p_crst = core_rst_o;
        p_cclk = core_clk_en_o; p_stop = stop_core_o; p_bank = bank_pwr_o;
        tick_ph = (tick_ph + 1) % 4;
        tick_i = (tick_ph == 0);
        if (tick_i) tickcnt++;
        xo_clkoff_i = stuck ? 1'b1 : !xo_clk_en_o;
    end

    task automatic run_vec(input int n);
        vec_t v = VEC[n];
        logic [NB-1:0] exp_bank;
        bit ordered;
        @(negedge clk); #1;
        cur_var = v.var_sel; variant_i = v.var_sel; stuck = v.stuck;
        arm_seq++;
        start_i = 1'b1;
        @(negedge clk); #1 start_i = 1'b0;
        // R2: resets held one cycle after start, nothing powered yet
        chk(core_rst_o && bus_rst_o && stop_core_o && !xo_clk_en_o && !hsw_on_o,
            $sformatf("R2 vec%0d reset/stop first", n),
            {core_rst_o, bus_rst_o, stop_core_o, xo_clk_en_o, hsw_on_o}, 5'b11100);
        // R11: next start clears the sticky flag
        chk(err_o == 1'b0, $sformatf("R11 vec%0d err cleared", n), err_o, 0);
        if (n == 1) begin
            while (!bank_pwr_o[25]) @(negedge clk);
            #1 start_i = 1'b1;
            @(negedge clk); #1 start_i = 1'b0;
            @(negedge clk);
            // R10: start while busy ignored
            chk(busy_o && bank_pwr_o[28] && bank_pwr_o[25],
                "R10 start ignored while busy", bank_pwr_o, 29'h12000000);
        end
        while (busy_o && stop_core_o) @(negedge clk);
        if (busy_o && v.send) begin
            repeat (3) @(negedge clk);
            #1 boot_valid_i = 1'b1; boot_code_i = v.code;
            @(negedge clk); #1 boot_valid_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        @(negedge clk);
        // R9 / R3: outcome code and flag
        chk(result_o == v.exp_res, $sformatf("R9 vec%0d result", n), result_o, v.exp_res);
        chk(err_o == (v.exp_res != 2'd1), $sformatf("R11 vec%0d err flag", n),
            err_o, (v.exp_res != 2'd1));
        // R7 / R6: bank count per variant
        exp_bank = v.stuck ? '0 : (v.var_sel ? 29'h1FFFFFFF : 29'h000FFFFF);
        chk(bank_pwr_o == exp_bank, $sformatf("R7 vec%0d banks", n), bank_pwr_o, exp_bank);
        if (v.stuck) begin
            // R3 / R11: timed-out handshake leaves controls held
            chk(xo_clk_en_o && core_rst_o && stop_core_o && !hsw_on_o,
                "R3 xo timeout holds controls",
                {xo_clk_en_o, core_rst_o, stop_core_o, hsw_on_o}, 4'b1110);
        end else begin
            ordered = 1;
            for (int k = 0; k < 11; k++) begin
                if (st[k] == 0) ordered = 0;
                if (k > 0 && st[k] <= st[k-1]) ordered = 0;
            end
            // R5 / R8: strict step order from clock enable to stop release
            chk(ordered, $sformatf("R8 vec%0d release order", n), st[10], 1);
        end
        repeat (5) @(negedge clk);
        // R11: flag and result persist in idle
        chk(result_o == v.exp_res && err_o == (v.exp_res != 2'd1),
            $sformatf("R11 vec%0d sticky", n), {err_o, result_o},
            {(v.exp_res != 2'd1), v.exp_res});
    endtask

    initial begin
        for (int k = 0; k < 11; k++) st[k] = 0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy_o && !err_o && result_o == 2'd0, "R1 idle/result", {busy_o, err_o, result_o}, 0);
        chk(!core_rst_o && !bus_rst_o && !stop_core_o && !xo_clk_en_o && !core_clk_en_o &&
            !hsw_on_o && !ldo_byp_o && !ret_n_o && !l2_stby_n_o && bank_pwr_o == '0,
            "R1 controls low", bank_pwr_o, 0);
        chk(mem_clamp_o && wl_clamp_o && io_clamp_o, "R1 clamps set",
            {mem_clamp_o, wl_clamp_o, io_clamp_o}, 3'b111);
        for (int n = 0; n < NV; n++) run_vec(n);
        // R4 and R6: monitor findings on settle gaps and ladder order
        chk(bad_r4 == 0, "R4 headswitch settle gap", bad_r4, 0);
        chk(bad_r6 == 0, "R6 bank ladder order/gap", bad_r6, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule